// File: doc/BRIEF.md
# Dual-Compare Pulse Output Unit

This unit drives one output line from two compare values that it matches against a 16-bit time base. Two time bases, each a free-running counter with its own period value, are presented as inputs. A select bit picks which one is watched. The unit does not build these counters itself. When the watched counter reaches the rise compare value, the output goes high. When the same counter later reaches the fall compare value, the output goes low again.

A 3-bit mode field selects the behaviour. In one-shot mode the unit makes a single pulse and then holds the output low. In train mode it re-arms itself on every counter cycle. Every falling edge is followed, two clock cycles later, by a sticky interrupt flag. Software clears the flag with a one-cycle clear strobe. A compare value above the selected period can never be reached, so the edge it would make is suppressed.

Top module: `dcp_unit`

## Requirements
- R1: Mode code 3'b101 selects the repeating train and 3'b100 selects the one-shot. Every other code, including 3'b000, keeps the output low and produces no events.
- R2: `tb_sel` = 0 watches `cnt_a` with `prd_a`, and `tb_sel` = 1 watches `cnt_b` with `prd_b`. Both compare values use the same selected time base.
- R3: While the output is low and armed, a cycle where the selected counter equals `cmp_rise` drives `pulse_out` high from the next clock edge.
- R4: While the output is high, a cycle where the selected counter equals `cmp_fall` drives `pulse_out` low from the next clock edge.
- R5: `irq_flag` becomes 1 two clock edges after the edge that drives `pulse_out` low on a fall match.
- R6: In one-shot mode, after the falling edge the output stays low and further matches are ignored. This lasts until the mode field changes or `en` is deasserted.
- R7: A fall compare value greater than the selected period gives no falling edge and no interrupt. A rise compare value greater than the period gives no rising edge.
- R8: In train mode, pulses repeat on later counter cycles with no change to the mode field and no disable.
- R9: `irq_flag` stays 1 until a cycle with `irq_clr` = 1. If a new delayed set and a clear meet in the same cycle, the set wins.
- R10: A change of the mode field, or `en` = 0, forces the output low on the next edge, clears the one-shot done state and cancels any interrupt still in the two-cycle delay.
- R11: When `cmp_rise` equals `cmp_fall`, a match keeps the output low and still raises `irq_flag` two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Unit enable |
| mode | input | 3 | Operating mode code |
| tb_sel | input | 1 | Time base select (0 = A, 1 = B) |
| cnt_a | input | 16 | Time base A counter value |
| prd_a | input | 16 | Time base A period value |
| cnt_b | input | 16 | Time base B counter value |
| prd_b | input | 16 | Time base B period value |
| cmp_rise | input | 16 | Compare value for the rising edge |
| cmp_fall | input | 16 | Compare value for the falling edge |
| irq_clr | input | 1 | One-cycle clear strobe for the interrupt flag |
| pulse_out | output | 1 | Pulse output |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench walks a pulse train and a one-shot cycle by cycle. It checks that a one-shot that did not latch would pulse again and that a flag delay off by one cycle would show on the wrong edge. It also sends a clear on the same cycle as a delayed set, so a design that gave the clear priority would lose an interrupt. Directed tests place compare values beyond the period, where a missing period gate would make an edge, and set equal compare values, where a naive design would emit a one-cycle glitch. A mode write between a falling edge and its interrupt must cancel the interrupt, and dropping the enable must pull a high output low at once.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_OFF     = 3'b000;
  localparam logic [MODE_W-1:0] MODE_ONESHOT = 3'b100;
  localparam logic [MODE_W-1:0] MODE_TRAIN   = 3'b101;

  // True for the two codes that run the compare logic
  function automatic logic is_pulse_mode(input logic [MODE_W-1:0] m);
    return (m == MODE_ONESHOT) || (m == MODE_TRAIN);
  endfunction
endpackage

// File: rtl/dcp_tb_select.sv
module dcp_tb_select #(
  parameter int unsigned W = 16
) (
  input  logic         sel,
  input  logic [W-1:0] cnt_a,
  input  logic [W-1:0] prd_a,
  input  logic [W-1:0] cnt_b,
  input  logic [W-1:0] prd_b,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] prd_o
);
  always_comb begin
    cnt_o = sel ? cnt_b : cnt_a;
    prd_o = sel ? prd_b : prd_a;
  end
endmodule

// File: rtl/dcp_match.sv
module dcp_match #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] prd,
  input  logic [W-1:0] cmp,
  output logic         hit
);
  // A compare value above the period is never reached, so it never hits
  function automatic logic reach_hit(input logic [W-1:0] c, input logic [W-1:0] p,
                                     input logic [W-1:0] v);
    return (c == v) && (v <= p);
  endfunction

  assign hit = reach_hit(cnt, prd, cmp);
endmodule

// File: rtl/dcp_irq_delay.sv
module dcp_irq_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic cancel,
  input  logic clr,
  output logic flag
);
  logic [DLY-1:0] pipe;
  logic           due;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pipe <= '0;
        else if (cancel) pipe <= '0;
        else             pipe <= evt;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pipe <= '0;
        else if (cancel) pipe <= '0;
        else             pipe <= {pipe[DLY-2:0], evt};
      end
    end
  endgenerate

  assign due = pipe[DLY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (due) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R5: the flag only rises when the delay chain delivers an event
  p_irq_from_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(due));
  // R9: a clear with no competing set drops the flag
  p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !due) |=> !flag);
  // R10: a cancel empties the delay chain
  p_cancel_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (pipe == '0));
endmodule

// File: rtl/dcp_unit.sv
module dcp_unit #(
  parameter int unsigned W       = 16,
  parameter int unsigned IRQ_DLY = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [dcp_pkg::MODE_W-1:0] mode,
  input  logic                       tb_sel,
  input  logic [W-1:0]               cnt_a,
  input  logic [W-1:0]               prd_a,
  input  logic [W-1:0]               cnt_b,
  input  logic [W-1:0]               prd_b,
  input  logic [W-1:0]               cmp_rise,
  input  logic [W-1:0]               cmp_fall,
  input  logic                       irq_clr,
  output logic                       pulse_out,
  output logic                       irq_flag
);
  import dcp_pkg::*;

  localparam int unsigned NCMP = 2;

  logic [W-1:0]        cnt_s, prd_s;
  logic [NCMP-1:0][W-1:0] cmp_v;
  logic [NCMP-1:0]     hit;
  logic                rise_hit, fall_hit, coincide;
  logic [MODE_W-1:0]   mode_q;
  logic                mode_chg, active, kill, armed;
  logic                rise_evt, fall_evt;
  logic                pin_q, done_q;

  dcp_tb_select #(.W(W)) u_sel (
    .sel(tb_sel), .cnt_a(cnt_a), .prd_a(prd_a), .cnt_b(cnt_b), .prd_b(prd_b),
    .cnt_o(cnt_s), .prd_o(prd_s)
  );

  assign cmp_v[0] = cmp_rise;
  assign cmp_v[1] = cmp_fall;

  generate
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      dcp_match #(.W(W)) u_match (
        .cnt(cnt_s), .prd(prd_s), .cmp(cmp_v[i]), .hit(hit[i])
      );
    end
  endgenerate

  assign rise_hit = hit[0];
  assign fall_hit = hit[1];
  assign coincide = rise_hit && fall_hit;

  // Named control events
  assign mode_chg = (mode != mode_q);
  assign active   = en && is_pulse_mode(mode);
  assign kill     = !active || mode_chg;
  assign armed    = !(done_q && (mode == MODE_ONESHOT));
  assign rise_evt = !kill && armed && !pin_q && rise_hit && !coincide;
  assign fall_evt = !kill && armed && ((pin_q && fall_hit) || (!pin_q && coincide));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pin_q <= 1'b0;
    else if (kill)     pin_q <= 1'b0;
    else if (rise_evt) pin_q <= 1'b1;
    else if (fall_evt) pin_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  done_q <= 1'b0;
    else if (kill)                               done_q <= 1'b0;
    else if (fall_evt && mode == MODE_ONESHOT)   done_q <= 1'b1;
  end

  dcp_irq_delay #(.DLY(IRQ_DLY)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(fall_evt), .cancel(kill), .clr(irq_clr),
    .flag(irq_flag)
  );

  assign pulse_out = pin_q;

  // R3: a rising edge is always preceded by a rise match
  p_rise_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_q) |-> $past(rise_hit));
  // R4: a falling edge comes from a fall match or a forced stop
  p_fall_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_q) |-> $past(fall_hit || kill));
  // R6: a finished one-shot stays low while not stopped
  p_oneshot_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !kill) |=> !pin_q);
  // R7: matches only occur at values the period can reach
  p_fall_within_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_hit |-> (cmp_fall <= prd_s));
  p_rise_within_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_hit |-> (cmp_rise <= prd_s));
  // R10: a stop forces the output low
  p_stop_forces_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !pin_q);
  // R11: equal compare values never produce a pulse from low
  p_equal_no_glitch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (coincide && !pin_q) |=> !pin_q);
endmodule

// File: tb/dcp_unit_tb.sv
module dcp_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int NV    = 28;

  // Row: {mode[3], sel[1], cnt_a[8], cnt_b[8], clr[1], exp_pin[1], exp_irq[1]}
  // Fixed setup: cmp_rise=3, cmp_fall=5, both periods 9, en=1
  localparam bit [22:0] TBL [NV] = '{
    {3'd5,1'b0,8'd0,8'd0,1'b0,1'b0,1'b0}, // 0  mode write forces low (R10)
    {3'd5,1'b0,8'd3,8'd0,1'b0,1'b1,1'b0}, // 1  rise match (R3)
    {3'd5,1'b0,8'd4,8'd0,1'b0,1'b1,1'b0}, // 2  held high
    {3'd5,1'b0,8'd5,8'd0,1'b0,1'b0,1'b0}, // 3  fall match (R4)
    {3'd5,1'b0,8'd6,8'd0,1'b0,1'b0,1'b0}, // 4  one edge later, flag still 0 (R5)
    {3'd5,1'b0,8'd7,8'd0,1'b0,1'b0,1'b1}, // 5  two edges later, flag set (R5)
    {3'd5,1'b0,8'd3,8'd0,1'b1,1'b1,1'b0}, // 6  re-armed (R8), clear (R9)
    {3'd5,1'b0,8'd5,8'd0,1'b0,1'b0,1'b0}, // 7  second pulse ends (R8)
    {3'd5,1'b0,8'd6,8'd0,1'b0,1'b0,1'b0}, // 8
    {3'd5,1'b0,8'd7,8'd0,1'b1,1'b0,1'b1}, // 9  set beats clear (R9)
    {3'd5,1'b0,8'd8,8'd0,1'b1,1'b0,1'b0}, // 10 clear (R9)
    {3'd4,1'b0,8'd0,8'd0,1'b0,1'b0,1'b0}, // 11 to one-shot
    {3'd4,1'b0,8'd3,8'd0,1'b0,1'b1,1'b0}, // 12 one-shot rise (R1)
    {3'd4,1'b0,8'd5,8'd0,1'b0,1'b0,1'b0}, // 13 one-shot fall
    {3'd4,1'b0,8'd3,8'd0,1'b0,1'b0,1'b0}, // 14 latched low (R6)
    {3'd4,1'b0,8'd4,8'd0,1'b0,1'b0,1'b1}, // 15 flag (R5)
    {3'd4,1'b0,8'd5,8'd0,1'b1,1'b0,1'b0}, // 16
    {3'd4,1'b0,8'd3,8'd0,1'b0,1'b0,1'b0}, // 17 still latched (R6)
    {3'd5,1'b0,8'd0,8'd0,1'b0,1'b0,1'b0}, // 18 back to train
    {3'd5,1'b1,8'd3,8'd0,1'b0,1'b0,1'b0}, // 19 base B at 0: A match ignored (R2)
    {3'd5,1'b1,8'd3,8'd3,1'b0,1'b1,1'b0}, // 20 base B rise (R2)
    {3'd5,1'b1,8'd5,8'd4,1'b0,1'b1,1'b0}, // 21 A fall value ignored (R2)
    {3'd5,1'b1,8'd0,8'd5,1'b0,1'b0,1'b0}, // 22 base B fall (R2)
    {3'd5,1'b0,8'd0,8'd0,1'b0,1'b0,1'b0}, // 23
    {3'd5,1'b0,8'd0,8'd0,1'b0,1'b0,1'b1}, // 24
    {3'd5,1'b0,8'd0,8'd0,1'b1,1'b0,1'b0}, // 25
    {3'd0,1'b0,8'd3,8'd0,1'b0,1'b0,1'b0}, // 26 off mode (R1)
    {3'd0,1'b0,8'd3,8'd0,1'b0,1'b0,1'b0}  // 27 off mode, no rise (R1)
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [2:0] mode = 3'd0;
  logic tb_sel = 1'b0;
  logic [W-1:0] cnt_a = '0, prd_a = 16'd9, cnt_b = '0, prd_b = 16'd9;
  logic [W-1:0] cmp_rise = 16'd3, cmp_fall = 16'd5;
  logic irq_clr = 1'b0;
  logic pulse_out, irq_flag;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dcp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .tb_sel(tb_sel),
    .cnt_a(cnt_a), .prd_a(prd_a), .cnt_b(cnt_b), .prd_b(prd_b),
    .cmp_rise(cmp_rise), .cmp_fall(cmp_fall), .irq_clr(irq_clr),
    .pulse_out(pulse_out), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs, let one edge pass, return 1 time unit after it
  task automatic step(input logic [2:0] m, input logic s, input int ca,
                      input int cb, input logic c);
    mode = m; tb_sel = s; cnt_a = W'(ca); cnt_b = W'(cb); irq_clr = c;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*4000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pin", pulse_out, 1'b0);
    chk("R1 reset irq", irq_flag, 1'b0);
    rst_n = 1'b1;
    step(3'd0, 1'b0, 0, 0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][22:20], TBL[i][19], int'(TBL[i][18:11]), int'(TBL[i][10:3]), TBL[i][2]);
      chk($sformatf("R1-row%0d pin", i), pulse_out, TBL[i][1]);
      chk($sformatf("R5-row%0d irq", i), irq_flag, TBL[i][0]);
    end

    // R7: fall value beyond period
    prd_a = 16'd4;
    step(3'd4, 1'b0, 0, 0, 1'b0);
    step(3'd5, 1'b0, 0, 0, 1'b0);
    step(3'd5, 1'b0, 3, 0, 1'b0); chk("R7 rise inside period", pulse_out, 1'b1);
    step(3'd5, 1'b0, 5, 0, 1'b0); chk("R7 no fall beyond period", pulse_out, 1'b1);
    step(3'd5, 1'b0, 6, 0, 1'b0);
    step(3'd5, 1'b0, 7, 0, 1'b0); chk("R7 no irq beyond period", irq_flag, 1'b0);
    // R7: rise value beyond period
    prd_a = 16'd2;
    step(3'd4, 1'b0, 0, 0, 1'b0);
    step(3'd5, 1'b0, 0, 0, 1'b0);
    step(3'd5, 1'b0, 3, 0, 1'b0); chk("R7 no rise beyond period", pulse_out, 1'b0);

    // R11: equal compare values
    prd_a = 16'd9; cmp_rise = 16'd4; cmp_fall = 16'd4;
    step(3'd4, 1'b0, 0, 0, 1'b0);
    step(3'd5, 1'b0, 0, 0, 1'b0);
    step(3'd5, 1'b0, 4, 0, 1'b0); chk("R11 equal stays low", pulse_out, 1'b0);
    step(3'd5, 1'b0, 5, 0, 1'b0); chk("R11 flag not early", irq_flag, 1'b0);
    step(3'd5, 1'b0, 6, 0, 1'b0); chk("R11 flag raised", irq_flag, 1'b1);
    step(3'd5, 1'b0, 6, 0, 1'b1); chk("R9 flag cleared", irq_flag, 1'b0);

    // R10: mode write cancels a pending interrupt
    cmp_rise = 16'd3; cmp_fall = 16'd5;
    step(3'd5, 1'b0, 3, 0, 1'b0); chk("R8 train rises", pulse_out, 1'b1);
    step(3'd5, 1'b0, 5, 0, 1'b0); chk("R4 train falls", pulse_out, 1'b0);
    step(3'd4, 1'b0, 6, 0, 1'b0);
    step(3'd4, 1'b0, 7, 0, 1'b0); chk("R10 pending irq cancelled", irq_flag, 1'b0);
    step(3'd4, 1'b0, 8, 0, 1'b0); chk("R10 still no irq", irq_flag, 1'b0);

    // R10: enable low forces the output low
    step(3'd5, 1'b0, 0, 0, 1'b0);
    step(3'd5, 1'b0, 3, 0, 1'b0); chk("R3 rise before disable", pulse_out, 1'b1);
    en = 1'b0;
    step(3'd5, 1'b0, 4, 0, 1'b0); chk("R10 disable forces low", pulse_out, 1'b0);
    en = 1'b1;
    step(3'd5, 1'b0, 5, 0, 1'b0); chk("R4 fall match while low ignored", pulse_out, 1'b0);
    step(3'd5, 1'b0, 6, 0, 1'b0);
    step(3'd5, 1'b0, 7, 0, 1'b0); chk("R10 no irq after disable", irq_flag, 1'b0);

    // R6: disable re-arms a finished one-shot
    step(3'd4, 1'b0, 0, 0, 1'b0);
    step(3'd4, 1'b0, 3, 0, 1'b0);
    step(3'd4, 1'b0, 5, 0, 1'b0);
    step(3'd4, 1'b0, 3, 0, 1'b0); chk("R6 one-shot latched", pulse_out, 1'b0);
    en = 1'b0;
    step(3'd4, 1'b0, 0, 0, 1'b0);
    en = 1'b1;
    step(3'd4, 1'b0, 3, 0, 1'b0); chk("R6 re-armed after disable", pulse_out, 1'b1);

    summary();
  end
endmodule